// File: doc/BRIEF.md
# Framed 24-bit serial command receiver

This block takes command words from a three-wire serial host link made of an active-low frame select, a serial clock and a data line. All three lines are brought into the system clock domain through two-flop synchronisers, and edges are found there. Inside an open frame, one bit is taken on every falling edge of the serial clock, most significant bit first. When the 24th bit lands, the word is locked. It is presented at once as an 8-bit control field and a 16-bit data field, marked by a single-cycle valid strobe. The block does not wait for frame select to rise before it does this.

If frame select rises before the word is complete, the partial frame is thrown away. Serial clocks that arrive after the word is locked do nothing. A fresh frame starts only on a new falling edge of frame select. While the disable input is high, the serial port is ignored altogether.

The output is a plain strobe with no ready signal, so there is no back-pressure. A consumer must take the word in the cycle the strobe is high. The word stays on the outputs until the next one arrives. The disable input is expected to be synchronous to the system clock. The system clock must run at least four times faster than the serial clock, and each serial clock phase must last at least two system cycles.

Top module: `sercmd_rx`

## Requirements
- R1: The asynchronous active-low reset clears the bit counter, the shift register and the outputs, so that cmd_valid=0, cmd_ctrl=0 and cmd_data=0. The first complete frame after reset is decoded correctly, even if reset arrived in the middle of a frame.
- R2: Bits are taken MSB first. The first bit received becomes word bit 23. cmd_ctrl carries word bits 23..16 and cmd_data carries word bits 15..0.
- R3: cmd_valid pulses high for exactly one system cycle, no more than 4 system cycles after the 24th serial clock falling edge, while frame select is still low. cmd_ctrl and cmd_data change only in a cycle where cmd_valid is high.
- R4: Once 24 bits are locked, further serial clock falling edges in the same frame raise no strobe and leave cmd_ctrl and cmd_data unchanged.
- R5: A rise of frame select before the 24th falling edge drops the frame. No strobe is raised and the outputs keep the previous word. The next full frame is decoded from a cleared register.
- R6: After a completed word, bits clocked while frame select stays low are ignored. Only a new falling edge of frame select opens a new frame.
- R7: While port_dis is high, no frame can start. A frame that is open when port_dis goes high is discarded and raises no strobe, even if clocking continues after port_dis returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_dis | input | 1 | Active-high disable; the serial port is ignored while high |
| ser_fs_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edges |
| ser_din | input | 1 | Serial data, MSB first |
| cmd_valid | output | 1 | One-cycle strobe marking a new word |
| cmd_ctrl | output | 8 | Control field of the last word (word bits 23..16) |
| cmd_data | output | 16 | Data field of the last word (word bits 15..0) |

## Verification
The bench sends a frame that stops at 23 bits. A receiver that ignores the early frame-select rise would strobe a shifted word, and one that fails to clear its counter would misalign the frame that follows. It also sends 24 extra clocks after a locked word and a second word with frame select held low. A design without the lock, or one that reopens a frame on its own, would raise a second strobe or overwrite the outputs. Raising the disable input in mid-frame, and resetting in mid-frame, show whether the abandoned state leaks into later words. Each normal frame is checked for its strobe before frame select rises, which catches a design that waits for the end of the frame.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_SHIFT  = 2'd1,
    RX_LOCKED = 2'd2
  } rx_state_e;

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sercmd_edge.sv
module sercmd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_s,
  input  logic sck_s,
  output logic fs_fall,
  output logic sck_fall
);

  logic fs_prev;
  logic sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      fs_prev  <= fs_s;
      sck_prev <= sck_s;
    end
  end

  assign fs_fall  = fs_prev & ~fs_s;
  assign sck_fall = sck_prev & ~sck_s;

endmodule

// File: rtl/sercmd_frame.sv
module sercmd_frame
  import sercmd_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dis,
  input  logic              fs_s,
  input  logic              fs_fall,
  input  logic              sck_fall,
  input  logic              din_s,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);

  localparam int              CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_next;

  assign shreg_next = {shreg[WORD_W-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (dis) begin
        state   <= RX_IDLE;
        bit_cnt <= '0;
        shreg   <= '0;
      end else begin
        unique case (state)
          RX_IDLE, RX_LOCKED: begin
            if (fs_fall) begin
              state   <= RX_SHIFT;
              bit_cnt <= '0;
              shreg   <= '0;
            end
          end
          RX_SHIFT: begin
            if (fs_s) begin
              state   <= RX_IDLE;
              bit_cnt <= '0;
              shreg   <= '0;
            end else if (sck_fall) begin
              shreg <= shreg_next;
              if (bit_cnt == LAST) begin
                state      <= RX_LOCKED;
                bit_cnt    <= '0;
                word_valid <= 1'b1;
                word       <= shreg_next;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sercmd_rx.sv
module sercmd_rx #(
  parameter int CTRL_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_dis,
  input  logic              ser_fs_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              cmd_valid,
  output logic [CTRL_W-1:0] cmd_ctrl,
  output logic [DATA_W-1:0] cmd_data
);

  localparam int WORD_W = CTRL_W + DATA_W;

  logic [2:0]        pins_s;
  logic              fs_s;
  logic              sck_s;
  logic              din_s;
  logic              fs_fall;
  logic              sck_fall;
  logic [WORD_W-1:0] word;

  sercmd_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_fs_n, ser_clk, ser_din}),
    .q     (pins_s)
  );

  assign fs_s  = pins_s[2];
  assign sck_s = pins_s[1];
  assign din_s = pins_s[0];

  sercmd_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_s     (fs_s),
    .sck_s    (sck_s),
    .fs_fall  (fs_fall),
    .sck_fall (sck_fall)
  );

  sercmd_frame #(
    .WORD_W (WORD_W)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .dis        (port_dis),
    .fs_s       (fs_s),
    .fs_fall    (fs_fall),
    .sck_fall   (sck_fall),
    .din_s      (din_s),
    .word_valid (cmd_valid),
    .word       (word)
  );

  assign cmd_ctrl = word[WORD_W-1:DATA_W];
  assign cmd_data = word[DATA_W-1:0];

endmodule

// File: rtl/sercmd_rx_chk.sv
module sercmd_rx_chk #(
  parameter int CTRL_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_dis,
  input logic              cmd_valid,
  input logic [CTRL_W-1:0] cmd_ctrl,
  input logic [DATA_W-1:0] cmd_data,
  input logic              fs_s,
  input logic              fs_fall
);

  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hit <= 1'b0;
    else if (fs_fall)   hit <= 1'b0;
    else if (cmd_valid) hit <= 1'b1;
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r3_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> ($stable(cmd_ctrl) && $stable(cmd_data)));

  a_r4_one_word_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !hit);

  a_r5_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(fs_s));

  a_r7_dis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(port_dis));

endmodule

bind sercmd_rx sercmd_rx_chk #(
  .CTRL_W (CTRL_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_dis  (port_dis),
  .cmd_valid (cmd_valid),
  .cmd_ctrl  (cmd_ctrl),
  .cmd_data  (cmd_data),
  .fs_s      (fs_s),
  .fs_fall   (fs_fall)
);

// File: tb/sercmd_rx_bench.sv
`timescale 1ns/1ps
module sercmd_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_dis = 1'b0;
  logic        ser_fs_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        cmd_valid;
  logic [7:0]  cmd_ctrl;
  logic [15:0] cmd_data;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int dbl = 0;
  bit prev_valid = 1'b0;
  bit done = 1'b0;

  localparam int NV = 6;
  localparam logic [23:0] VEC   [NV] = '{24'hFFFFFF, 24'h000001, 24'h800000,
                                         24'h5A3C96, 24'h123456, 24'hC0FFEE};
  localparam logic [7:0]  EXP_C [NV] = '{8'hFF, 8'h00, 8'h80, 8'h5A, 8'h12, 8'hC0};
  localparam logic [15:0] EXP_D [NV] = '{16'hFFFF, 16'h0001, 16'h0000,
                                         16'h3C96, 16'h3456, 16'hFFEE};

  always #2.5 clk = ~clk;

  sercmd_rx u_sercmd_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_dis  (port_dis),
    .ser_fs_n  (ser_fs_n),
    .ser_clk   (ser_clk),
    .ser_din   (ser_din),
    .cmd_valid (cmd_valid),
    .cmd_ctrl  (cmd_ctrl),
    .cmd_data  (cmd_data)
  );

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      pulses++;
      if (prev_valid) dbl++;
    end
    prev_valid = rst_n && cmd_valid;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame_open();
    ser_fs_n = 1'b0;
    cyc(4);
  endtask

  task automatic frame_close();
    cyc(6);
    ser_fs_n = 1'b1;
    cyc(8);
  endtask

  task automatic send_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ser_din = w[23 - (i % 24)];
      ser_clk = 1'b1;
      cyc(4);
      ser_clk = 1'b0;
      cyc(4);
    end
  endtask

  task automatic check_word(input string req, input logic [23:0] w);
    chk(cmd_ctrl == w[23:16], req, cmd_ctrl, w[23:16]);
    chk(cmd_data == w[15:0], req, cmd_data, w[15:0]);
  endtask

  task automatic full_frame(input string req, input logic [23:0] w);
    int p0;
    p0 = pulses;
    frame_open();
    send_bits(w, 24);
    cyc(1);
    chk(pulses == p0 + 1, req, pulses - p0, 1);
    frame_close();
    check_word(req, w);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    cyc(3);
    // R1: reset state
    chk(cmd_valid == 1'b0, "R1 reset valid", cmd_valid, 0);
    check_word("R1 reset word", 24'h0);
    rst_n = 1'b1;
    cyc(4);

    // R2 / R3: table of frames
    for (int v = 0; v < NV; v++) begin
      p0 = pulses;
      frame_open();
      send_bits(VEC[v], 24);
      cyc(1);
      chk(pulses == p0 + 1, "R3 strobe before frame end", pulses - p0, 1);
      frame_close();
      chk(cmd_ctrl == EXP_C[v], "R2 ctrl field", cmd_ctrl, EXP_C[v]);
      chk(cmd_data == EXP_D[v], "R2 data field", cmd_data, EXP_D[v]);
    end
    chk(dbl == 0, "R3 single-cycle strobe", dbl, 0);

    // R5: early frame end
    p0 = pulses;
    frame_open();
    send_bits(24'hABCDEF, 23);
    frame_close();
    chk(pulses == p0, "R5 partial frame dropped", pulses - p0, 0);
    check_word("R5 outputs held", 24'hC0FFEE);
    p0 = pulses;
    frame_open();
    send_bits(24'h777777, 10);
    frame_close();
    full_frame("R5 fresh frame after abort", 24'h3A5001);

    // R4: extra clocks after lock
    p0 = pulses;
    frame_open();
    send_bits(24'h9E1F20, 24);
    send_bits(24'h55AA33, 24);
    frame_close();
    chk(pulses == p0 + 1, "R4 extra clocks no strobe", pulses - p0, 1);
    check_word("R4 word locked", 24'h9E1F20);

    // R6: frame select held low after word
    p0 = pulses;
    frame_open();
    send_bits(24'h0F0F0F, 24);
    cyc(6);
    send_bits(24'hF0F0F0, 24);
    frame_close();
    chk(pulses == p0 + 1, "R6 no frame without fs fall", pulses - p0, 1);
    check_word("R6 word kept", 24'h0F0F0F);
    full_frame("R6 new frame after fs fall", 24'h2468AC);

    // R7: disabled port
    port_dis = 1'b1;
    cyc(2);
    p0 = pulses;
    frame_open();
    send_bits(24'hDEAD01, 24);
    frame_close();
    port_dis = 1'b0;
    cyc(2);
    chk(pulses == p0, "R7 disabled frame ignored", pulses - p0, 0);
    check_word("R7 outputs held", 24'h2468AC);
    p0 = pulses;
    frame_open();
    send_bits(24'hBEEF02, 10);
    port_dis = 1'b1;
    cyc(3);
    port_dis = 1'b0;
    send_bits(24'hBEEF02 << 10, 14);
    frame_close();
    chk(pulses == p0, "R7 mid-frame disable drops frame", pulses - p0, 0);
    full_frame("R7 frame after disable", 24'h13579B);

    // R1: reset in mid-frame
    frame_open();
    send_bits(24'hFFFFFF, 10);
    #1.2 rst_n = 1'b0;
    cyc(2);
    chk(cmd_valid == 1'b0, "R1 mid-frame reset valid", cmd_valid, 0);
    check_word("R1 mid-frame reset word", 24'h0);
    ser_fs_n = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    full_frame("R1 frame after reset", 24'h6B0C4D);
    chk(dbl == 0, "R3 single-cycle strobe final", dbl, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule